// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Controller

This block is one DMA channel that moves words between an I/O device and memory without holding the data. The data goes straight from the source to the sink on the shared bus. While the processor owns the bus, it programs three registers through a select/register-select slave port: the start memory address, a transfer count and a mode word. The processor reads back the same three registers through this port.

Once the channel is enabled, a request from the device makes the channel ask the processor for the bus. The channel then waits for the grant. For each word it moves, it acknowledges the device, drives the memory address and raises one matched pair of strobes: I/O read with memory write, or memory read with I/O write. After each word the count steps down and the address steps up or down.

Three bus-release policies are available: one word per grant, the whole block per grant, or words for as long as the device keeps requesting. A transfer ends when the count wraps below zero or when the external end input is asserted. Either event raises an interrupt and a status flag, and both stay set until the mode word is rewritten.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, the bus request, bus drive enable, device acknowledge, all four strobes, the end output and the interrupt are low, and all three registers read back as zero.
- R2: The channel raises the bus request only when it is enabled, not finished, and sees the device request. Until the grant input is seen high, it keeps the drive enable, acknowledge and strobes low.
- R3: In every word cycle, the channel drives the acknowledge and the drive enable high together with exactly two strobes. Mode bit 3 = 0 selects I/O read with memory write. Mode bit 3 = 1 selects memory read with I/O write.
- R4: Each word cycle puts the current address on the address output. After the word, the count decrements by 1 and the address moves by 1 with wrap-around: up when mode bit 2 = 0, down when mode bit 2 = 1.
- R5: A word moved while the count is zero is the last word, so a programmed count N gives N+1 words. During that word the end output is high. Afterwards the bus is released, the count reads all-ones, the interrupt is high and status bit 5 of the mode register reads 1.
- R6: If the external end input is high during a word cycle, that word is the last one. The channel releases the bus and sets the interrupt and the status bit as in R5.
- R7: With mode bits [1:0] = 00 (single), the bus request is low in the cycle after every word.
- R8: With mode bits [1:0] = 01 (block), the channel moves words back to back while the grant holds, whether or not the device request is high.
- R9: With mode bits [1:0] = 10 (demand), the channel moves the next word only if the device request is high at the end of the current word. Otherwise it releases the bus, and it resumes when the request returns.
- R10: If the grant is low at the end of a word cycle, that word completes. In the next cycle the drive enable and the acknowledge are low.
- R11: The register select picks the register: 0 is the address, 1 is the count, 2 is the mode. Mode bit 4 is the enable. A write to any register while the channel is moving a word has no effect.
- R12: While the channel is disabled (mode bit 4 = 0) or finished, it ignores the device request. A write to the mode register clears the status bit and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csel_i | input | 1 | Slave port select |
| rsel_i | input | 2 | Register select |
| cpu_rd_i | input | 1 | Processor register read |
| cpu_wr_i | input | 1 | Processor register write |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data, zero when not read |
| dev_req_i | input | 1 | Device transfer request |
| dev_ack_o | output | 1 | Acknowledge to the device during a word |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_gnt_i | input | 1 | Bus grant from the processor |
| bus_oe_o | output | 1 | High while address and strobes are driven; low means float |
| mem_addr_o | output | ADDR_W | Memory address during a word |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| end_in_i | input | 1 | External end of transfer |
| end_out_o | output | 1 | High during the terminal-count word |
| irq_o | output | 1 | Transfer-finished interrupt |

## Verification
Three events can land on the same word. The count can reach zero in the cycle where the external end input is raised, where the grant is withdrawn, or where a processor register write arrives. The bench provokes each case with directed runs that set the external end, or drop the grant, on exactly the word the count makes last. Random runs aim a count write at a word cycle. In each case the bench expects one finished transfer, not two effects, and checks it after the fact: a single release of the bus, end output high on that word only, the count reading all-ones, the interrupt set, and no further word even with the device still requesting.

// File: rtl/flyby_dma_pkg.sv
`timescale 1ns/1ps
package flyby_dma_pkg;

   typedef enum logic [1:0] {
      XM_SINGLE = 2'b00,
      XM_BLOCK  = 2'b01,
      XM_DEMAND = 2'b10,
      XM_RSVD   = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_REQ  = 2'b01,
      ST_MOVE = 2'b10
   } chan_state_e;

   // [4] enable, [3] memory-to-device, [2] address decrements, [1:0] mode
   typedef struct packed {
      logic       enable;
      logic       mem_to_dev;
      logic       dec;
      xfer_mode_e mode;
   } mode_word_t;

   localparam int MODE_W = $bits(mode_word_t);

   localparam logic [1:0] RSEL_ADDR = 2'd0;
   localparam logic [1:0] RSEL_CNT  = 2'd1;
   localparam logic [1:0] RSEL_MODE = 2'd2;

endpackage

// File: rtl/flyby_dma_regs.sv
`timescale 1ns/1ps
module flyby_dma_regs
   import flyby_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        rsel_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              step_i,
   input  logic              finish_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  cnt_o,
   output mode_word_t        mode_o,
   output logic              done_o,
   output logic              cnt_zero_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int STAT_W = MODE_W + 1;

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   mode_word_t        mode_q;
   logic              done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q <= '0;
         cnt_q  <= '0;
         mode_q <= '0;
         done_q <= 1'b0;
      end else begin
         if (wr_en_i) begin
            unique case (rsel_i)
               RSEL_ADDR: addr_q <= wdata_i[ADDR_W-1:0];
               RSEL_CNT:  cnt_q  <= wdata_i[CNT_W-1:0];
               RSEL_MODE: begin
                  mode_q <= mode_word_t'(wdata_i[MODE_W-1:0]);
                  done_q <= 1'b0;
               end
               default: ;
            endcase
         end else if (step_i) begin
            cnt_q  <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
            addr_q <= mode_q.dec ? addr_q - {{(ADDR_W-1){1'b0}}, 1'b1}
                                 : addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
         end
         if (finish_i) done_q <= 1'b1;
      end
   end

   assign addr_o     = addr_q;
   assign cnt_o      = cnt_q;
   assign mode_o     = mode_q;
   assign done_o     = done_q;
   assign cnt_zero_o = (cnt_q == '0);

   logic [DATA_W-1:0] addr_ext, cnt_ext, stat_ext;

   generate
      if (DATA_W > ADDR_W) begin : g_addr_pad
         assign addr_ext = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
      end else begin : g_addr_full
         assign addr_ext = addr_q;
      end
      if (DATA_W > CNT_W) begin : g_cnt_pad
         assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
      end else begin : g_cnt_full
         assign cnt_ext = cnt_q;
      end
      if (DATA_W > STAT_W) begin : g_stat_pad
         assign stat_ext = {{(DATA_W-STAT_W){1'b0}}, done_q, mode_q};
      end else begin : g_stat_full
         assign stat_ext = {done_q, mode_q};
      end
   endgenerate

   always_comb begin
      unique case (rsel_i)
         RSEL_ADDR: rdata_o = addr_ext;
         RSEL_CNT:  rdata_o = cnt_ext;
         RSEL_MODE: rdata_o = stat_ext;
         default:   rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/flyby_dma_seq.sv
`timescale 1ns/1ps
module flyby_dma_seq
   import flyby_dma_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       dev_req_i,
   input  logic       bus_gnt_i,
   input  logic       end_in_i,
   input  mode_word_t mode_i,
   input  logic       done_i,
   input  logic       cnt_zero_i,
   output logic       moving_o,
   output logic       step_o,
   output logic       finish_o,
   output logic       bus_req_o
);

   chan_state_e state_q, state_d;
   logic        last_word;
   logic        armed;

   assign armed     = mode_i.enable && !done_i;
   assign moving_o  = (state_q == ST_MOVE);
   assign last_word = moving_o && (cnt_zero_i || end_in_i);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (armed && dev_req_i) state_d = ST_REQ;
         ST_REQ:  if (bus_gnt_i) state_d = ST_MOVE;
         ST_MOVE: begin
            if (last_word || !bus_gnt_i) begin
               state_d = ST_IDLE;
            end else begin
               unique case (mode_i.mode)
                  XM_BLOCK:  state_d = ST_MOVE;
                  XM_DEMAND: state_d = dev_req_i ? ST_MOVE : ST_IDLE;
                  default:   state_d = ST_IDLE;
               endcase
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign step_o    = moving_o;
   assign finish_o  = last_word;
   assign bus_req_o = (state_q != ST_IDLE);

endmodule

// File: rtl/flyby_dma_chan.sv
`timescale 1ns/1ps
module flyby_dma_chan
   import flyby_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              csel_i,
   input  logic [1:0]        rsel_i,
   input  logic              cpu_rd_i,
   input  logic              cpu_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              dev_req_i,
   output logic              dev_ack_o,
   output logic              bus_req_o,
   input  logic              bus_gnt_i,
   output logic              bus_oe_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              io_rd_o,
   output logic              io_wr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   input  logic              end_in_i,
   output logic              end_out_o,
   output logic              irq_o
);

   generate
      if (DATA_W < ADDR_W || DATA_W < CNT_W || DATA_W < MODE_W + 1) begin : g_bad_width
         $error("flyby_dma_chan: DATA_W too narrow for register readback");
      end
      if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_size
         $error("flyby_dma_chan: ADDR_W and CNT_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   mode_word_t        mode_q;
   logic              done_q, cnt_zero, moving, step, finish;
   logic              reg_wr, reg_rd;
   logic [DATA_W-1:0] reg_rdata;
   logic              mode_single, addr_dec;

   assign reg_wr = csel_i && cpu_wr_i && !moving;
   assign reg_rd = csel_i && cpu_rd_i && !moving;

   flyby_dma_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (reg_wr),
      .rsel_i     (rsel_i),
      .wdata_i    (wdata_i),
      .step_i     (step),
      .finish_i   (finish),
      .addr_o     (addr_q),
      .cnt_o      (cnt_q),
      .mode_o     (mode_q),
      .done_o     (done_q),
      .cnt_zero_o (cnt_zero),
      .rdata_o    (reg_rdata)
   );

   flyby_dma_seq u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dev_req_i  (dev_req_i),
      .bus_gnt_i  (bus_gnt_i),
      .end_in_i   (end_in_i),
      .mode_i     (mode_q),
      .done_i     (done_q),
      .cnt_zero_i (cnt_zero),
      .moving_o   (moving),
      .step_o     (step),
      .finish_o   (finish),
      .bus_req_o  (bus_req_o)
   );

   assign rdata_o    = reg_rd ? reg_rdata : '0;
   assign bus_oe_o   = moving;
   assign dev_ack_o  = moving;
   assign mem_addr_o = moving ? addr_q : '0;
   assign io_rd_o    = moving && !mode_q.mem_to_dev;
   assign mem_wr_o   = moving && !mode_q.mem_to_dev;
   assign mem_rd_o   = moving &&  mode_q.mem_to_dev;
   assign io_wr_o    = moving &&  mode_q.mem_to_dev;
   assign end_out_o  = moving && cnt_zero;
   assign irq_o      = done_q;

   assign mode_single = (mode_q.mode == XM_SINGLE) || (mode_q.mode == XM_RSVD);
   assign addr_dec    = mode_q.dec;

endmodule

module flyby_dma_chan_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              bus_oe,
   input logic              dev_ack,
   input logic              io_rd,
   input logic              io_wr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              end_in,
   input logic              end_out,
   input logic              irq,
   input logic              single,
   input logic              dec
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   assert_grant_before_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $past(bus_gnt));

   assert_paired_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (dev_ack && $countones({io_rd, io_wr, mem_rd, mem_wr}) == 2
                  && io_rd == mem_wr && io_rd != io_wr));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe)) |-> (mem_addr == (dec ? $past(mem_addr) - ONE
                                                      : $past(mem_addr) + ONE)));

   assert_tc_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      end_out |=> (irq && !bus_oe));

   assert_ext_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && end_in) |=> (irq && !bus_oe));

   assert_single_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && single) |=> !bus_req);

   assert_grant_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !bus_gnt) |=> (!bus_oe && !dev_ack));

   assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bus_req) |=> !bus_req);

endmodule

bind flyby_dma_chan flyby_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .bus_req  (bus_req_o),
   .bus_gnt  (bus_gnt_i),
   .bus_oe   (bus_oe_o),
   .dev_ack  (dev_ack_o),
   .io_rd    (io_rd_o),
   .io_wr    (io_wr_o),
   .mem_rd   (mem_rd_o),
   .mem_wr   (mem_wr_o),
   .mem_addr (mem_addr_o),
   .end_in   (end_in_i),
   .end_out  (end_out_o),
   .irq      (irq_o),
   .single   (mode_single),
   .dec      (addr_dec)
);

// File: tb/flyby_dma_chan_tb.sv
`timescale 1ns/1ps
module flyby_dma_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csel = 0, cpu_rd = 0, cpu_wr = 0;
   logic [1:0]  rsel = 0;
   logic [15:0] wdata = 0;
   logic [15:0] rdata;
   logic        dev_req = 0, bus_gnt = 0, end_in = 0;
   logic        dev_ack, bus_req, bus_oe, io_rd, io_wr, mem_rd, mem_wr, end_out, irq;
   logic [15:0] mem_addr;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   flyby_dma_chan u_dut (
      .clk_i(clk), .rst_ni(rst_n), .csel_i(csel), .rsel_i(rsel),
      .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr), .wdata_i(wdata), .rdata_o(rdata),
      .dev_req_i(dev_req), .dev_ack_o(dev_ack), .bus_req_o(bus_req),
      .bus_gnt_i(bus_gnt), .bus_oe_o(bus_oe), .mem_addr_o(mem_addr),
      .io_rd_o(io_rd), .io_wr_o(io_wr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
      .end_in_i(end_in), .end_out_o(end_out), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic [15:0] start, input int n, input bit dec);
      return dec ? start - 16'(n) : start + 16'(n);
   endfunction

   function automatic logic [15:0] exp_cnt(input logic [15:0] cnt, input int n);
      return cnt - 16'(n);
   endfunction

   function automatic logic [15:0] mode_word(input bit en, input bit m2d, input bit dec, input int mode);
      return {11'd0, en, m2d, dec, 2'(mode)};
   endfunction

   task automatic reg_wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      csel = 1; cpu_wr = 1; rsel = sel; wdata = d;
      @(negedge clk);
      csel = 0; cpu_wr = 0;
   endtask

   task automatic reg_rd(input logic [1:0] sel, output logic [15:0] v);
      @(negedge clk);
      csel = 1; cpu_rd = 1; rsel = sel;
      #1 v = rdata;
      csel = 0; cpu_rd = 0;
   endtask

   task automatic run_xfer(input int mode, input bit dec, input bit m2d,
                           input logic [15:0] start, input logic [15:0] cnt,
                           input int end_at, input int drop_at, input bit wr_try);
      int          words = 0;
      int          total;
      int          cyc = 0;
      bit          w, last, drop, dropped = 0;
      bit          exp_word = 0, exp_gap = 0, exp_rel = 0;
      string       gap_req = "R5";
      logic [15:0] ea = start;
      logic [15:0] v;
      string       term_req;
      total    = (end_at >= 0 && end_at < int'(cnt) + 1) ? end_at + 1 : int'(cnt) + 1;
      term_req = (end_at >= 0 && end_at < int'(cnt)) ? "R6" : "R5";
      dev_req = 0; bus_gnt = 0; end_in = 0;
      reg_wr(2'd0, start);
      reg_wr(2'd1, cnt);
      dev_req = 1;
      reg_wr(2'd2, mode_word(1, m2d, dec, mode));
      while (words < total && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         w = bus_oe;
         if (exp_word) chk(w, mode == 1 ? "R8" : "R9", "next word back to back", 32'(w), 1);
         if (exp_gap)  chk(!w && !dev_ack, gap_req, "bus released after word", 32'(w), 0);
         if (exp_rel)  chk(!bus_req, "R7", "single mode drops request", 32'(bus_req), 0);
         exp_word = 0; exp_gap = 0; exp_rel = 0;
         csel = 0; cpu_wr = 0; end_in = 0;
         last = 0;
         if (w) begin
            chk(mem_addr == ea, "R4", "word address", 32'(mem_addr), 32'(ea));
            chk(dev_ack, "R3", "device acknowledge", 32'(dev_ack), 1);
            chk(m2d ? (mem_rd && io_wr && !io_rd && !mem_wr) : (io_rd && mem_wr && !mem_rd && !io_wr),
                "R3", "strobe pair", 32'({io_rd, io_wr, mem_rd, mem_wr}),
                m2d ? 32'b0110 : 32'b1001);
            words++;
            last = (words == total);
            chk(end_out == (words == int'(cnt) + 1), "R5", "end output on count-zero word",
                32'(end_out), 32'(words == int'(cnt) + 1));
            ea = dec ? ea - 16'd1 : ea + 16'd1;
         end
         drop = w && (drop_at == words - 1);
         if (drop) dropped = 1;
         if (w && end_at == words - 1) end_in = 1;
         if (wr_try && w && words == 1) begin
            csel = 1; cpu_wr = 1; rsel = 2'd1; wdata = 16'h1234;
         end
         if (drop) bus_gnt = 0;
         else      bus_gnt = bus_req && (bus_gnt || ($urandom % 3) != 0);
         case (mode)
            0:       dev_req = 1'($urandom % 2);
            1:       dev_req = (words == 0) || (dropped && !bus_req);
            default: dev_req = ($urandom % 4) != 0;
         endcase
         if (w) begin
            if (last || drop || mode == 0 || (mode == 2 && !dev_req)) begin
               exp_gap = 1;
               gap_req = last ? term_req : drop ? "R10" : mode == 0 ? "R7" : "R9";
            end else begin
               exp_word = 1;
            end
            if (mode == 0) exp_rel = 1;
         end
      end
      chk(words == total, term_req, "word total", 32'(words), 32'(total));
      @(negedge clk);
      csel = 0; cpu_wr = 0; end_in = 0; bus_gnt = 0; dev_req = 1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!bus_req && !bus_oe, "R12", "request ignored after finish", 32'(bus_req), 0);
      end
      chk(irq, term_req, "interrupt set", 32'(irq), 1);
      reg_rd(2'd1, v);
      chk(v == exp_cnt(cnt, total), term_req, "count readback (write during word ignored, R11)",
          32'(v), 32'(exp_cnt(cnt, total)));
      reg_rd(2'd0, v);
      chk(v == exp_addr(start, total, dec), "R4", "address readback",
          32'(v), 32'(exp_addr(start, total, dec)));
      reg_rd(2'd2, v);
      chk(v == (mode_word(1, m2d, dec, mode) | 16'h0020), "R11", "mode readback with status bit 5",
          32'(v), 32'(mode_word(1, m2d, dec, mode) | 16'h0020));
      dev_req = 0;
      reg_wr(2'd2, mode_word(0, m2d, dec, mode));
      chk(!irq, "R12", "mode write clears interrupt", 32'(irq), 0);
      reg_rd(2'd2, v);
      chk(v[5] == 1'b0, "R12", "mode write clears status", 32'(v[5]), 0);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!bus_req && !bus_oe && !dev_ack && !irq && !end_out, "R1", "idle outputs",
          32'({bus_req, bus_oe, dev_ack, irq, end_out}), 0);
      chk(!io_rd && !io_wr && !mem_rd && !mem_wr, "R1", "strobes low",
          32'({io_rd, io_wr, mem_rd, mem_wr}), 0);
      for (int s = 0; s < 3; s++) begin
         reg_rd(2'(s), v);
         chk(v == 16'h0, "R1", "register zero after reset", 32'(v), 0);
      end
      // R12 disabled channel ignores request
      reg_wr(2'd2, mode_word(0, 0, 0, 1));
      dev_req = 1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(!bus_req, "R12", "disabled ignores request", 32'(bus_req), 0);
      end
      dev_req = 0;
      // R2 wait for grant
      reg_wr(2'd0, 16'h0100);
      reg_wr(2'd1, 16'h0000);
      reg_wr(2'd2, mode_word(1, 0, 0, 0));
      dev_req = 1;
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(bus_req && !bus_oe && !dev_ack && !io_rd && !mem_wr, "R2", "request held, no drive before grant",
             32'({bus_req, bus_oe, dev_ack}), 32'b100);
      end
      bus_gnt = 1;
      @(negedge clk);
      chk(bus_oe && mem_addr == 16'h0100, "R2", "word after grant", 32'(mem_addr), 32'h0100);
      bus_gnt = 0; dev_req = 0;
      @(negedge clk);
      chk(irq && !bus_oe, "R5", "count zero gives one word", 32'(irq), 1);
      reg_wr(2'd2, 16'h0000);
      // directed corners
      run_xfer(1, 0, 0, 16'hFFFE, 16'd3, -1, -1, 1);   // wrap, block, write in word (R11)
      run_xfer(1, 1, 1, 16'h0002, 16'd4, 2, -1, 0);    // external end mid-block (R6), decrement
      run_xfer(1, 0, 1, 16'h4000, 16'd2, 2, -1, 0);    // end input coincides with count zero
      run_xfer(2, 0, 0, 16'h2000, 16'd6, -1, 2, 0);    // grant loss mid demand (R10)
      run_xfer(1, 0, 0, 16'h3000, 16'd3, -1, 3, 1);    // grant loss on the terminal word
      run_xfer(0, 1, 0, 16'h0001, 16'd5, -1, -1, 0);   // single, decrement through zero
      // constrained random
      for (int t = 0; t < 14; t++) begin
         int          m  = int'($urandom % 3);
         logic [15:0] c  = 16'($urandom % 20);
         int          ea = (($urandom % 4) == 0) ? int'($urandom % (int'(c) + 1)) : -1;
         int          da = (($urandom % 4) == 0) ? int'($urandom % (int'(c) + 1)) : -1;
         run_xfer(m, 1'($urandom % 2), 1'($urandom % 2), 16'($urandom), c, ea, da, 1'($urandom % 2));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule